// File: doc/BRIEF.md
# Two-Operand Instruction Execute Unit

This block is the execute stage for the two-operand group of a 16-bit instruction set. A separate sequencer fetches both operands. It then presents the instruction word, the source value, the destination value, and two facts about the destination: whether it is a general register, and for a memory destination, whether the byte address is odd. The unit decodes the operation and works at byte or word width. It produces the value to write back, a per-byte write-enable mask and the new N/Z/V/C condition codes, and it flags opcodes outside the group as illegal.

The instruction word is split as opcode in bits 15:12, source specifier in bits 11:6 and destination specifier in bits 5:0. Only the opcode matters here. The specifiers belong to the sequencer. For byte operations the source byte is taken from bits 7:0 of `src_val`, because the sequencer aligns it. The destination byte is taken from the lane that the destination selects. With the default `REG_OUT = 1`, results are registered and appear one clock after `in_valid`. When `in_valid` is low, the registered outputs hold.

Top module: `dop_exec`

## Requirements
- R1: The opcode is bits 15:12. Opcodes 0000, 0111, 1000 and 1111 are illegal: `illegal` = 1, `wr_en` = 0, `lane_sel` = 00, and `flags_out` equals `flags_in`. Flags are packed as {N,Z,V,C} in bits 3..0.
- R2: Opcode x001 (bit 15 = byte form) moves the source: result = source, N/Z from the result at the active width, V = 0, C kept from `flags_in`.
- R3: A byte move (1001) to a register sign-extends source bit 7 into bits 15:8 and writes both lanes (`lane_sel` = 11).
- R4: Opcode x010 sets N/Z/V/C from source minus destination, where C is the borrow out. It writes nothing (`wr_en` = 0, `lane_sel` = 00).
- R5: Opcode x011 sets N/Z from source AND destination, sets V = 0 and keeps C. It writes nothing.
- R6: Opcode x100 writes destination AND NOT source. Opcode x101 writes destination OR source. Both set V = 0 and keep C.
- R7: Opcode 0110 writes destination + source at word width, even though bit 15 is clear. C is the carry out and V is the signed overflow.
- R8: Opcode 1110 writes destination − source at word width, even though bit 15 is set. C is the borrow out and V is the signed overflow.
- R9: A byte operation on a memory destination uses the addressed byte: the high byte when `dst_odd` = 1, otherwise the low byte. It writes only that lane (`lane_sel` bit 1 = high byte, bit 0 = low byte), and the other byte of `result` equals the destination word.
- R10: A byte operation other than a move on a register destination acts on bits 7:0. It sets `lane_sel` = 01 and passes bits 15:8 of the destination through to `result`.
- R11: Outputs update one clock after a cycle with `in_valid` = 1. `out_valid` follows `in_valid` with one cycle of delay. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and instruction are present |
| instr | input | 16 | Instruction word |
| src_val | input | DATA_W | Source operand; byte forms use bits 7:0 |
| dst_val | input | DATA_W | Destination word as read |
| dst_is_reg | input | 1 | Destination is a general register |
| dst_odd | input | 1 | Memory destination byte address is odd |
| flags_in | input | 4 | Current {N,Z,V,C} |
| out_valid | output | 1 | Outputs carry a new result |
| result | output | DATA_W | Value to write back |
| wr_en | output | 1 | Write-back requested |
| lane_sel | output | 2 | Byte lanes written: bit 1 high, bit 0 low |
| flags_out | output | 4 | New {N,Z,V,C} |
| illegal | output | 1 | Opcode outside the group |

## Verification
Two things can happen in the same cycle: a byte-width flag computation, and a lane merge that keeps the other byte of the destination word. This can make N and Z disagree with the full 16-bit result while both are still correct. The bench provokes it with byte operations on odd and even memory addresses and on registers, using upper bytes that carry a different sign and zero state from the operated byte. Each case is judged on the merged word, the lane mask and the flags together. A second collision is bit 15 acting as a byte selector for every opcode except add and subtract. The bench exercises it with subtract operands whose low bytes alone would give a different answer.

// File: rtl/dop_pkg.sv
package dop_pkg;

   localparam int INSN_W = 16;
   localparam int OPC_W  = 4;

   typedef enum logic [2:0] {
      OP_MOV  = 3'd0,
      OP_CMP  = 3'd1,
      OP_BIT  = 3'd2,
      OP_BIC  = 3'd3,
      OP_BIS  = 3'd4,
      OP_ADD  = 3'd5,
      OP_SUB  = 3'd6,
      OP_NONE = 3'd7
   } dop_op_e;

   typedef struct packed {
      dop_op_e op;
      logic    byte_mode;
      logic    writes;
      logic    illegal;
   } dop_ctl_t;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } dop_flags_t;

endpackage

// File: rtl/dop_decode.sv
module dop_decode
   import dop_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output dop_ctl_t         ctl
);

   always_comb begin
      ctl.op        = OP_NONE;
      ctl.byte_mode = 1'b0;
      ctl.writes    = 1'b0;
      ctl.illegal   = 1'b0;
      unique case (opc[OPC_W-2:0])
         3'd1: begin ctl.op = OP_MOV; ctl.byte_mode = opc[OPC_W-1]; ctl.writes = 1'b1; end
         3'd2: begin ctl.op = OP_CMP; ctl.byte_mode = opc[OPC_W-1]; end
         3'd3: begin ctl.op = OP_BIT; ctl.byte_mode = opc[OPC_W-1]; end
         3'd4: begin ctl.op = OP_BIC; ctl.byte_mode = opc[OPC_W-1]; ctl.writes = 1'b1; end
         3'd5: begin ctl.op = OP_BIS; ctl.byte_mode = opc[OPC_W-1]; ctl.writes = 1'b1; end
         3'd6: begin
            ctl.op     = opc[OPC_W-1] ? OP_SUB : OP_ADD;
            ctl.writes = 1'b1;
         end
         default: ctl.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/dop_arith.sv
module dop_arith
   import dop_pkg::*;
#(
   parameter int WD = 16
) (
   input  dop_op_e       op,
   input  logic [WD-1:0] src,
   input  logic [WD-1:0] dst,
   input  logic          c_in,
   output logic [WD-1:0] res,
   output dop_flags_t    fl
);

   logic [WD:0] ext;

   always_comb begin
      ext  = '0;
      res  = dst;
      fl.v = 1'b0;
      fl.c = c_in;
      unique case (op)
         OP_MOV: res = src;
         OP_CMP: begin
            ext  = {1'b0, src} - {1'b0, dst};
            res  = ext[WD-1:0];
            fl.c = ext[WD];
            fl.v = (src[WD-1] ^ dst[WD-1]) & (res[WD-1] ^ src[WD-1]);
         end
         OP_BIT: res = src & dst;
         OP_BIC: res = dst & ~src;
         OP_BIS: res = dst | src;
         OP_ADD: begin
            ext  = {1'b0, dst} + {1'b0, src};
            res  = ext[WD-1:0];
            fl.c = ext[WD];
            fl.v = ~(src[WD-1] ^ dst[WD-1]) & (res[WD-1] ^ dst[WD-1]);
         end
         OP_SUB: begin
            ext  = {1'b0, dst} - {1'b0, src};
            res  = ext[WD-1:0];
            fl.c = ext[WD];
            fl.v = (src[WD-1] ^ dst[WD-1]) & (res[WD-1] ^ dst[WD-1]);
         end
         default: res = dst;
      endcase
      fl.n = res[WD-1];
      fl.z = (res == '0);
   end

endmodule

// File: rtl/dop_lanes.sv
module dop_lanes #(
   parameter int DATA_W = 16
) (
   input  logic              byte_mode,
   input  logic              writes,
   input  logic              is_move,
   input  logic              dst_is_reg,
   input  logic              dst_odd,
   input  logic [DATA_W-1:0] res,
   input  logic [DATA_W-1:0] dst,
   output logic [DATA_W-1:0] merged,
   output logic [1:0]        lanes
);

   localparam int BW = DATA_W / 2;

   logic [BW-1:0] rb;
   assign rb = res[BW-1:0];

   always_comb begin
      if (!byte_mode) begin
         merged = res;
         lanes  = 2'b11;
      end else if (dst_is_reg && is_move) begin
         merged = {{BW{rb[BW-1]}}, rb};
         lanes  = 2'b11;
      end else if (!dst_is_reg && dst_odd) begin
         merged = {rb, dst[BW-1:0]};
         lanes  = 2'b10;
      end else begin
         merged = {dst[DATA_W-1:BW], rb};
         lanes  = 2'b01;
      end
      if (!writes) lanes = 2'b00;
   end

endmodule

// File: rtl/dop_exec.sv
module dop_exec
   import dop_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] instr,
   input  logic [DATA_W-1:0] src_val,
   input  logic [DATA_W-1:0] dst_val,
   input  logic              dst_is_reg,
   input  logic              dst_odd,
   input  logic [3:0]        flags_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic [1:0]        lane_sel,
   output logic [3:0]        flags_out,
   output logic              illegal
);

   localparam int BW     = DATA_W / 2;
   localparam int N_WIDE = 2;

   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
      $error("dop_exec: DATA_W must be even and at least 4");
   end

   dop_ctl_t   ctl;
   dop_flags_t fin;
   logic       odd_lane;
   logic       unused_spec;

   assign fin         = dop_flags_t'(flags_in);
   assign unused_spec = ^instr[INSN_W-OPC_W-1:0];

   dop_decode u_decode (
      .opc (instr[INSN_W-1:INSN_W-OPC_W]),
      .ctl (ctl)
   );

   // destination operand aligned so the addressed byte sits in the low lane
   logic [DATA_W-1:0] dst_op;
   assign odd_lane = ctl.byte_mode & ~dst_is_reg & dst_odd;
   assign dst_op   = odd_lane ? {{BW{1'b0}}, dst_val[DATA_W-1:BW]} : dst_val;

   // one arithmetic core per width: index 0 byte, index 1 word
   logic [DATA_W-1:0] ar_res [N_WIDE];
   dop_flags_t        ar_fl  [N_WIDE];

   for (genvar g = 0; g < N_WIDE; g++) begin : g_width
      localparam int WD = (g == 0) ? BW : DATA_W;
      logic [WD-1:0] r_loc;
      dop_arith #(.WD(WD)) u_arith (
         .op   (ctl.op),
         .src  (src_val[WD-1:0]),
         .dst  (dst_op[WD-1:0]),
         .c_in (fin.c),
         .res  (r_loc),
         .fl   (ar_fl[g])
      );
      assign ar_res[g] = DATA_W'(r_loc);
   end

   logic [DATA_W-1:0] sel_res;
   dop_flags_t        sel_fl;
   assign sel_res = ar_res[ctl.byte_mode ? 0 : 1];
   assign sel_fl  = ctl.illegal ? fin : ar_fl[ctl.byte_mode ? 0 : 1];

   logic [DATA_W-1:0] nxt_result;
   logic [1:0]        nxt_lanes;
   logic              nxt_wr;

   assign nxt_wr = ctl.writes & ~ctl.illegal;

   dop_lanes #(.DATA_W(DATA_W)) u_lanes (
      .byte_mode  (ctl.byte_mode),
      .writes     (nxt_wr),
      .is_move    (ctl.op == OP_MOV),
      .dst_is_reg (dst_is_reg),
      .dst_odd    (dst_odd),
      .res        (sel_res),
      .dst        (dst_val),
      .merged     (nxt_result),
      .lanes      (nxt_lanes)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            lane_sel  <= 2'b00;
            flags_out <= 4'h0;
            illegal   <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result    <= nxt_result;
               wr_en     <= nxt_wr;
               lane_sel  <= nxt_lanes;
               flags_out <= sel_fl;
               illegal   <= ctl.illegal;
            end
         end
      end
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign result    = nxt_result;
      assign wr_en     = nxt_wr;
      assign lane_sel  = nxt_lanes;
      assign flags_out = sel_fl;
      assign illegal   = ctl.illegal;
   end

endmodule

// File: rtl/dop_exec_chk.sv
module dop_exec_chk #(
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [15:0]       instr,
   input logic [DATA_W-1:0] src_val,
   input logic [DATA_W-1:0] dst_val,
   input logic              dst_is_reg,
   input logic              dst_odd,
   input logic [3:0]        flags_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic [1:0]        lane_sel,
   input logic [3:0]        flags_out,
   input logic              illegal
);

   localparam int BW = DATA_W / 2;

   p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> (!wr_en && lane_sel == 2'b00));

   p_word_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wr_en && lane_sel == 2'b11) |->
         (flags_out[3] == result[DATA_W-1] && flags_out[2] == (result == '0)));

   p_high_lane_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wr_en && lane_sel == 2'b10) |->
         (flags_out[3] == result[DATA_W-1] && flags_out[2] == (result[DATA_W-1:BW] == '0)));

   p_low_lane_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wr_en && lane_sel == 2'b01) |->
         (flags_out[3] == result[BW-1] && flags_out[2] == (result[BW-1:0] == '0)));

   p_lane_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (wr_en == (lane_sel != 2'b00)));

   if (REG_OUT) begin : g_seq
      p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $past(in_valid));

      p_flags_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && illegal) |-> (flags_out == $past(flags_in)));

      p_compare_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(instr[14:12] == 3'd2)) |-> !wr_en);

      p_test_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(instr[14:12] == 3'd3)) |-> (!wr_en && !flags_out[1]));
   end

endmodule

bind dop_exec dop_exec_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/dop_exec_bench.sv
module dop_exec_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] src_val = '0;
   logic [15:0] dst_val = '0;
   logic        dst_is_reg = 1'b0;
   logic        dst_odd = 1'b0;
   logic [3:0]  flags_in = '0;
   logic        out_valid;
   logic [15:0] result;
   logic        wr_en;
   logic [1:0]  lane_sel;
   logic [3:0]  flags_out;
   logic        illegal;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dop_exec u_dop_exec (.*);

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // opcode in bits 15:12, arbitrary specifiers below
   function automatic logic [15:0] mk(input logic [3:0] opc);
      return {opc, 12'o2704};
   endfunction

   task automatic run(input string req, input logic [3:0] opc, input logic [15:0] s, input logic [15:0] d,
                      input logic is_reg, input logic odd, input logic [3:0] fin,
                      input logic chk_res, input logic [15:0] e_res, input logic e_wr,
                      input logic [1:0] e_lane, input logic [3:0] e_fl, input logic e_ill);
      @(negedge clk);
      instr = mk(opc); src_val = s; dst_val = d; dst_is_reg = is_reg; dst_odd = odd;
      flags_in = fin; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "out_valid", 32'(out_valid), 32'(1'b1));
      if (chk_res) chk(req, "result", 32'(result), 32'(e_res));
      chk(req, "wr_en", 32'(wr_en), 32'(e_wr));
      chk(req, "lane_sel", 32'(lane_sel), 32'(e_lane));
      chk(req, "flags", 32'(flags_out), 32'(e_fl));
      chk(req, "illegal", 32'(illegal), 32'(e_ill));
   endtask

   task automatic t_reset_r11();
      chk("R11", "rst out_valid", 32'(out_valid), 32'd0);
      chk("R11", "rst result", 32'(result), 32'd0);
      chk("R11", "rst wr_en", 32'(wr_en), 32'd0);
      chk("R11", "rst flags", 32'(flags_out), 32'd0);
   endtask

   task automatic t_move_r2();
      run("R2", 4'b0001, 16'h8000, 16'h1234, 1'b0, 1'b0, 4'b0011, 1'b1, 16'h8000, 1'b1, 2'b11, 4'b1001, 1'b0);
      run("R2", 4'b0001, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 4'b0000, 1'b1, 16'h0000, 1'b1, 2'b11, 4'b0100, 1'b0);
   endtask

   task automatic t_move_byte_reg_r3();
      run("R3", 4'b1001, 16'h1280, 16'h5555, 1'b1, 1'b0, 4'b0001, 1'b1, 16'hFF80, 1'b1, 2'b11, 4'b1001, 1'b0);
      run("R3", 4'b1001, 16'hF07F, 16'h5555, 1'b1, 1'b0, 4'b0000, 1'b1, 16'h007F, 1'b1, 2'b11, 4'b0000, 1'b0);
   endtask

   task automatic t_compare_r4();
      run("R4", 4'b0010, 16'h0005, 16'h0007, 1'b1, 1'b0, 4'b0000, 1'b0, 16'h0, 1'b0, 2'b00, 4'b1001, 1'b0);
      run("R4", 4'b0010, 16'h1234, 16'h1234, 1'b1, 1'b0, 4'b0011, 1'b0, 16'h0, 1'b0, 2'b00, 4'b0100, 1'b0);
      run("R4", 4'b0010, 16'h8000, 16'h0001, 1'b1, 1'b0, 4'b0000, 1'b0, 16'h0, 1'b0, 2'b00, 4'b0010, 1'b0);
      // byte compare: 80 - 01 = 7F, signed overflow
      run("R4", 4'b1010, 16'h0080, 16'hFF01, 1'b1, 1'b0, 4'b0000, 1'b0, 16'h0, 1'b0, 2'b00, 4'b0010, 1'b0);
   endtask

   task automatic t_bit_test_r5();
      run("R5", 4'b0011, 16'hF0F0, 16'h0F0F, 1'b1, 1'b0, 4'b0011, 1'b0, 16'h0, 1'b0, 2'b00, 4'b0101, 1'b0);
      run("R5", 4'b1011, 16'h0080, 16'h00C0, 1'b0, 1'b0, 4'b0000, 1'b0, 16'h0, 1'b0, 2'b00, 4'b1000, 1'b0);
   endtask

   task automatic t_clear_set_r6();
      run("R6", 4'b0100, 16'h00FF, 16'hFFFF, 1'b1, 1'b0, 4'b0011, 1'b1, 16'hFF00, 1'b1, 2'b11, 4'b1001, 1'b0);
      run("R6", 4'b0101, 16'h0101, 16'h1010, 1'b0, 1'b0, 4'b0010, 1'b1, 16'h1111, 1'b1, 2'b11, 4'b0000, 1'b0);
   endtask

   task automatic t_add_r7();
      run("R7", 4'b0110, 16'h0001, 16'h7FFF, 1'b1, 1'b0, 4'b0000, 1'b1, 16'h8000, 1'b1, 2'b11, 4'b1010, 1'b0);
      run("R7", 4'b0110, 16'h0001, 16'hFFFF, 1'b1, 1'b0, 4'b0000, 1'b1, 16'h0000, 1'b1, 2'b11, 4'b0101, 1'b0);
   endtask

   task automatic t_sub_r8();
      run("R8", 4'b1110, 16'h0005, 16'h0003, 1'b1, 1'b0, 4'b0000, 1'b1, 16'hFFFE, 1'b1, 2'b11, 4'b1001, 1'b0);
      // low bytes equal: a byte-mode subtract would give zero
      run("R8", 4'b1110, 16'h0034, 16'h1234, 1'b1, 1'b0, 4'b0101, 1'b1, 16'h1200, 1'b1, 2'b11, 4'b0000, 1'b0);
   endtask

   task automatic t_mem_byte_r9();
      run("R9", 4'b1001, 16'h0042, 16'hABCD, 1'b0, 1'b1, 4'b0000, 1'b1, 16'h42CD, 1'b1, 2'b10, 4'b0000, 1'b0);
      run("R9", 4'b1100, 16'h0080, 16'h80FF, 1'b0, 1'b1, 4'b0000, 1'b1, 16'h00FF, 1'b1, 2'b10, 4'b0100, 1'b0);
      run("R9", 4'b1101, 16'h0080, 16'h0001, 1'b0, 1'b0, 4'b0000, 1'b1, 16'h0081, 1'b1, 2'b01, 4'b1000, 1'b0);
      // byte move to memory does not sign-extend
      run("R9", 4'b1001, 16'h0090, 16'h3300, 1'b0, 1'b0, 4'b0000, 1'b1, 16'h3390, 1'b1, 2'b01, 4'b1000, 1'b0);
   endtask

   task automatic t_reg_byte_r10();
      run("R10", 4'b1101, 16'h0001, 16'hAA80, 1'b1, 1'b0, 4'b0000, 1'b1, 16'hAA81, 1'b1, 2'b01, 4'b1000, 1'b0);
      // dst_odd is ignored for a register destination
      run("R10", 4'b1100, 16'h00FF, 16'h7712, 1'b1, 1'b1, 4'b0001, 1'b1, 16'h7700, 1'b1, 2'b01, 4'b0101, 1'b0);
   endtask

   task automatic t_illegal_r1();
      logic [3:0] bad [4] = '{4'b0000, 4'b0111, 4'b1000, 4'b1111};
      for (int i = 0; i < 4; i++)
         run("R1", bad[i], 16'h1111, 16'h2222, 1'b1, 1'b0, 4'b1010, 1'b0, 16'h0, 1'b0, 2'b00, 4'b1010, 1'b1);
   endtask

   task automatic t_idle_r11();
      @(negedge clk);
      in_valid = 1'b0;
      instr = mk(4'b0001); src_val = 16'hDEAD;
      @(posedge clk);
      @(negedge clk);
      chk("R11", "idle out_valid", 32'(out_valid), 32'd0);
      chk("R11", "idle hold result", 32'(result), 32'h1111);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1;
      t_reset_r11();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_move_r2();
      t_move_byte_reg_r3();
      t_compare_r4();
      t_bit_test_r5();
      t_clear_set_r6();
      t_add_r7();
      t_sub_r8();
      t_mem_byte_r9();
      t_reg_byte_r10();
      t_illegal_r1();
      // last written result before idle: 0x1111 from R6 is not latest; re-run a move
      run("R11", 4'b0001, 16'h1111, 16'h0000, 1'b1, 1'b0, 4'b0000, 1'b1, 16'h1111, 1'b1, 2'b11, 4'b0000, 1'b0);
      t_idle_r11();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #200000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

endmodule